// File: doc/BRIEF.md
# Four-Bit Serial GPIO Slave

This block is the device-side end of a small serial link through which a host microcontroller sets four general-purpose outputs and reads back four general-purpose inputs. The link has a clock, one shared data line, a direction line and a reset line. When the direction line is low the host shifts four bits into the block, one bit on each clock transition. The new value reaches the GPIO outputs only once the last bit is in.

A rising edge on the direction line captures the GPIO inputs. The block then drives the data line and returns the captured value highest bit first. Each later clock transition steps the data line to the next lower bit.

The block samples all link pins in a fast system clock domain. The system clock must run at least four times faster than the host toggles. Each pin passes through a two-flop synchronizer, and every edge is found by comparing the synchronized value with its copy from the previous cycle. The shared data line is split into an input, an output and an output enable, and the pad outside the block joins them.

Top module: `sgpio_slave`

## Requirements
- R1: While `rst_ni` is low, `gpio_o` is 0 and `sdat_oe_o` is 0.
- R2: With direction low, a write carries four bits on `sdat_i`, bit 0 first. Bit 0 is taken on a rising `sclk_i` edge, bit 1 on a falling edge, bit 2 on a rising edge and bit 3 on a falling edge. `gpio_o` keeps its old value until the fourth bit arrives, then takes all four bits at once.
- R3: During a write, a clock edge of the wrong polarity for the expected bit is ignored. For example, a falling edge while bit 0 is awaited does not consume a bit.
- R4: A write that stops before four bits leaves `gpio_o` unchanged. A rising edge on the direction line discards the partial bits, and the next write starts again from bit 0.
- R5: `sdat_oe_o` is 1 only while the synchronized direction line is high and the host reset is inactive.
- R6: A rising edge of `sdir_i` latches `gpio_i`, and `sdat_o` then presents bit 3.
- R7: While direction is high, every `sclk_i` edge of either polarity moves `sdat_o` to the next lower bit. After bit 0, `sdat_o` shows 0.
- R8: If a direction rise and a clock edge land in the same synchronized cycle, the latch wins and the edge does not shift. `sdat_o` shows bit 3.
- R9: While `srst_i` is high, `gpio_o` is 0, `sdat_oe_o` is 0 and any partial write is discarded.
- R10: A pin change shows at the outputs after the third rising edge of `clk_i` that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| sclk_i | input | 1 | Link clock from the host, idles low |
| sdir_i | input | 1 | Link direction: 0 means host writes, 1 means block drives data |
| srst_i | input | 1 | Link reset from the host, active high |
| sdat_i | input | 1 | Data line, input side |
| sdat_o | output | 1 | Data line, output side |
| sdat_oe_o | output | 1 | Output enable for the data line pad |
| gpio_i | input | N_BITS | GPIO values captured for a read |
| gpio_o | output | N_BITS | GPIO output register |

## Verification
Two functions can meet in one system cycle: the direction-rise latch and the clock-edge shift. The bench provokes this by changing `sclk_i` and `sdir_i` in the same time step, so both pass through the synchronizers together. It then judges the outcome by the first bit on `sdat_o`, which must be bit 3 and not bit 2 of the captured input. A second collision, a stray falling edge while direction is low left over from a read, is judged by whether the next full write still lands intact on `gpio_o`.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int unsigned SGPIO_BITS  = 4;
  localparam int unsigned SGPIO_SYNC  = 2;
  // synchronizer lane order
  localparam int unsigned LANE_CLK = 0;
  localparam int unsigned LANE_DIR = 1;
  localparam int unsigned LANE_DAT = 2;
  localparam int unsigned LANE_RST = 3;
  localparam int unsigned LANES    = 4;
endpackage

// File: rtl/sgpio_sync.sv
module sgpio_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= pipe_q[STAGES-1];
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sgpio_wr_path.sv
module sgpio_wr_path #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,    // drop partial word
  input  logic         zero_i,   // clear output register
  input  logic         edge_i,
  input  logic         level_i,  // clock level after the edge
  input  logic         bit_i,
  output logic [N-1:0] word_o
);
  localparam int unsigned CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N-1);

  logic [CW-1:0] cnt_q;
  logic [N-1:0]  sh_q, full;
  logic          take;

  // even bit index expects a rising edge, odd a falling edge
  assign take = edge_i && (level_i == ~cnt_q[0]);

  always_comb begin
    full         = sh_q;
    full[N-1]    = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      word_o <= '0;
    end else begin
      if (zero_i) word_o <= '0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q[cnt_q] <= bit_i;
        if (cnt_q == LAST) begin
          word_o <= full;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sgpio_rd_path.sv
module sgpio_rd_path #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [N-1:0] data_i,
  output logic         bit_o
);
  logic [N-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= data_i;               // latch beats shift
    else if (shift_i) sh_q <= {sh_q[N-2:0], 1'b0};
  end

  assign bit_o = sh_q[N-1];
endmodule

// File: rtl/sgpio_slave.sv
module sgpio_slave
  import sgpio_pkg::*;
#(
  parameter int unsigned N_BITS      = SGPIO_BITS,
  parameter int unsigned SYNC_STAGES = SGPIO_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdir_i,
  input  logic              srst_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  input  logic [N_BITS-1:0] gpio_i,
  output logic [N_BITS-1:0] gpio_o
);
  logic [LANES-1:0] pins, pins_s, pins_p;
  logic clk_s, dir_s, dat_s, rst_s;
  logic clk_edge, dir_rise, oe_q;

  always_comb begin
    pins           = '0;
    pins[LANE_CLK] = sclk_i;
    pins[LANE_DIR] = sdir_i;
    pins[LANE_DAT] = sdat_i;
    pins[LANE_RST] = srst_i;
  end

  sgpio_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins),
    .sync_o  (pins_s),
    .prev_o  (pins_p)
  );

  assign clk_s    = pins_s[LANE_CLK];
  assign dir_s    = pins_s[LANE_DIR];
  assign dat_s    = pins_s[LANE_DAT];
  assign rst_s    = pins_s[LANE_RST];
  assign clk_edge = pins_s[LANE_CLK] ^ pins_p[LANE_CLK];
  assign dir_rise = pins_s[LANE_DIR] & ~pins_p[LANE_DIR];

  sgpio_wr_path #(.N(N_BITS)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (dir_s | rst_s),
    .zero_i  (rst_s),
    .edge_i  (clk_edge),
    .level_i (clk_s),
    .bit_i   (dat_s),
    .word_o  (gpio_o)
  );

  sgpio_rd_path #(.N(N_BITS)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rst_s),
    .load_i  (dir_rise),
    .shift_i (clk_edge & dir_s),
    .data_i  (gpio_i),
    .bit_o   (sdat_o)
  );

  // enable rises on the same edge that loads the read register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= dir_s & ~rst_s;
  end

  assign sdat_oe_o = oe_q;
endmodule

// File: rtl/sgpio_slave_chk.sv
module sgpio_slave_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         dir_s,
  input logic         rst_s,
  input logic         clk_edge,
  input logic         dir_rise,
  input logic [N-1:0] gpio_i,
  input logic [N-1:0] gpio_o,
  input logic         sdat_o,
  input logic         sdat_oe_o
);
  assert_read_mode_holds_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_s && !rst_s) |=> $stable(gpio_o));

  assert_host_reset_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_s |=> (gpio_o == '0 && !sdat_oe_o));

  assert_latch_msb_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rise && !rst_s) |=> (sdat_oe_o && sdat_o == $past(gpio_i[N-1])));

  assert_shift_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdat_oe_o && $past(sdat_oe_o) && !$stable(sdat_o)) |-> $past(clk_edge || dir_rise));

  assert_oe_follows_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdat_oe_o |-> $past(dir_s && !rst_s));
endmodule

bind sgpio_slave sgpio_slave_chk #(.N(N_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dir_s     (dir_s),
  .rst_s     (rst_s),
  .clk_edge  (clk_edge),
  .dir_rise  (dir_rise),
  .gpio_i    (gpio_i),
  .gpio_o    (gpio_o),
  .sdat_o    (sdat_o),
  .sdat_oe_o (sdat_oe_o)
);

// File: tb/sgpio_slave_tb.sv
module sgpio_slave_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdir_i = 1'b0, srst_i = 1'b0, sdat_i = 1'b0;
  logic sdat_o, sdat_oe_o;
  logic [N-1:0] gpio_i = '0;
  logic [N-1:0] gpio_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgpio_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdir_i(sdir_i),
    .srst_i(srst_i), .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o),
    .gpio_i(gpio_i), .gpio_o(gpio_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [N-1:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      sdat_i = v[i];
      settle(2);
      sclk_i = ~sclk_i;
      settle(6);
    end
  endtask

  task automatic write_word(input logic [N-1:0] v, input string req);
    logic [N-1:0] old;
    old = gpio_o;
    send_bits(v, 0, N-2);
    check(gpio_o == old, "R2 no half value", gpio_o, old);
    send_bits(v, N-1, N-1);
    check(gpio_o == v, req, gpio_o, v);
  endtask

  task automatic t_reset();
    check(gpio_o == '0, "R1 gpio", gpio_o, 0);
    check(sdat_oe_o == 1'b0, "R1 oe", sdat_oe_o, 0);
  endtask

  task automatic t_write();
    write_word(4'hA, "R2 write A");
    write_word(4'h5, "R2 write 5");
    write_word(4'hF, "R2 write F");
    write_word(4'h0, "R2 write 0");
    write_word(4'h9, "R2 write 9");
  endtask

  task automatic t_read();
    gpio_i = 4'hB;
    sdir_i = 1'b1;
    settle(6);
    check(sdat_oe_o == 1'b1, "R5 oe high", sdat_oe_o, 1);
    check(sdat_o == 1'b1, "R6 bit3", sdat_o, 1);
    gpio_i = 4'h0;   // latched value must persist
    sclk_i = 1'b1;
    settle(2);
    check(sdat_o == 1'b1, "R10 not after 2 clocks", sdat_o, 1);
    settle(1);
    check(sdat_o == 1'b0, "R10 after 3 clocks", sdat_o, 0);
    settle(3);
    check(sdat_o == 1'b0, "R7 bit2", sdat_o, 0);
    sclk_i = 1'b0;
    settle(6);
    check(sdat_o == 1'b1, "R7 bit1 falling edge", sdat_o, 1);
    sclk_i = 1'b1;
    settle(6);
    check(sdat_o == 1'b1, "R7 bit0", sdat_o, 1);
    sclk_i = 1'b0;
    settle(6);
    check(sdat_o == 1'b0, "R7 zero after bit0", sdat_o, 0);
    sclk_i = 1'b1;
    settle(6);
    sdir_i = 1'b0;
    settle(6);
    check(sdat_oe_o == 1'b0, "R5 oe low", sdat_oe_o, 0);
    check(gpio_o == 4'h9, "R4 read leaves gpio", gpio_o, 9);
  endtask

  task automatic t_polarity();
    // clock left high by the read; falling edge while bit0 awaited
    sdat_i = 1'b1;
    settle(2);
    sclk_i = 1'b0;
    settle(6);
    write_word(4'h6, "R3 stray fall ignored");
  endtask

  task automatic t_partial();
    send_bits(4'h3, 0, 1);
    sdir_i = 1'b1;
    settle(6);
    sdir_i = 1'b0;
    settle(6);
    check(gpio_o == 4'h6, "R4 partial discarded", gpio_o, 6);
    write_word(4'hC, "R4 restart at bit0");
  endtask

  task automatic t_same_cycle();
    gpio_i = 4'b1001;
    sclk_i = 1'b1;
    sdir_i = 1'b1;
    settle(6);
    check(sdat_o == 1'b1, "R8 latch beats shift", sdat_o, 1);
    sclk_i = 1'b0;
    settle(6);
    check(sdat_o == 1'b0, "R8 then bit2", sdat_o, 0);
    sdir_i = 1'b0;
    settle(6);
  endtask

  task automatic t_host_reset();
    send_bits(4'h3, 0, 1);
    srst_i = 1'b1;
    sdir_i = 1'b1;
    settle(6);
    check(gpio_o == '0, "R9 gpio cleared", gpio_o, 0);
    check(sdat_oe_o == 1'b0, "R9 oe low", sdat_oe_o, 0);
    srst_i = 1'b0;
    sdir_i = 1'b0;
    settle(6);
    write_word(4'h7, "R9 partial dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    settle(4);
    t_reset();
    t_write();
    t_read();
    t_polarity();
    t_partial();
    t_same_cycle();
    t_host_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule